// File: doc/BRIEF.md
# L3 Three-Wire Serial Write Master

This block drives the three-wire control bus that audio codecs use for configuration. The three outputs are a mode line, a data line and a bus clock. The master drives all three lines, and it only writes. A host places an 8-bit value and a mode bit on the inputs and pulses start. The block then moves the mode line to the requested level and waits a setup interval with the bus clock high. It shifts the byte out least significant bit first, one bus clock per bit, and returns the lines to idle.

The setup interval and each bus clock phase are counted in system clocks. The mode line level tells the codec whether the byte is an address or a data byte: a low level marks an address byte and a high level marks a data byte. The host watches busy to know when it may start the next byte, and a one-cycle done pulse marks the end of each transfer. The byte is captured when start is accepted. A start that arrives during a transfer is dropped.

Top module: `l3w_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, mode_o=1, bus_clk_o=1, dat_o=0, busy_o=0 and done_o=0.
- R2: During a transfer, mode_o equals the mode_i value captured at the accepted start (0 = address byte, 1 = data byte). It holds that value without change until busy_o falls.
- R3: After the start is accepted, there are exactly SETUP_CYCLES busy cycles with bus_clk_o=1 and dat_o=0 before the first falling edge of bus_clk_o.
- R4: A transfer carries exactly 8 bits, bit 0 of the captured byte first. Each bit is on dat_o for its whole low phase and high phase. dat_o changes during a transfer only in cycles where bus_clk_o is low.
- R5: Every low phase and every high phase of bus_clk_o during a transfer lasts exactly HALF_PERIOD_CYCLES system clocks.
- R6: busy_o rises in the cycle after the accepted start and stays high for exactly SETUP_CYCLES + 16*HALF_PERIOD_CYCLES cycles.
- R7: done_o is high for exactly one cycle: the first cycle after busy_o falls.
- R8: A start_i pulse while busy_o=1 is ignored. No extra transfer follows, and the transfer in progress is not changed.
- R9: byte_i and mode_i are captured on the accepted start. Later changes to them do not affect the transfer in progress.
- R10: Whenever busy_o=0, the lines sit at mode_o=1, bus_clk_o=1 and dat_o=0. This includes the cycle right after the eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; taken only when idle |
| byte_i | input | 8 | Byte to send |
| mode_i | input | 1 | Mode line level for this transfer (0 address, 1 data) |
| mode_o | output | 1 | Bus mode line |
| bus_clk_o | output | 1 | Bus clock line, high when idle |
| dat_o | output | 1 | Bus data line |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with SETUP_CYCLES=3 and HALF_PERIOD_CYCLES=2. A whole transfer then takes 35 cycles, so many bytes fit in a short run, including back-to-back starts and a start dropped mid-transfer. At these values the setup counter is still distinct from the phase counter, so an off-by-one in either length shows up as a wrong busy length or a wrong phase length. Byte patterns 0x01 and 0x80 put a single one at each end of the shift, which exposes a reversed bit order.

// File: rtl/l3w_pkg.sv
package l3w_pkg;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } l3w_state_e;
endpackage

// File: rtl/l3w_phase_timer.sv
module l3w_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R5
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/l3w_shift_reg.sv
module l3w_shift_reg #(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NBITS-1:0] data_i,
  input  logic             adv_i,
  output logic             bit_o,
  output logic             last_o
);
  localparam int unsigned CW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(NBITS - 1);

  logic [NBITS-1:0] sh_q;
  logic [CW-1:0]    idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= '0;
    end else if (adv_i) begin
      sh_q  <= sh_q >> 1;  // lsb first
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (idx_q == LAST_IDX);

  // R4
  no_adv_past_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |-> !last_o);
endmodule

// File: rtl/l3w_ctrl.sv
module l3w_ctrl
  import l3w_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tmr_zero_i,
  input  logic       last_bit_i,
  output logic       tmr_load_o,
  output logic       tmr_setup_o,
  output logic       cap_o,
  output logic       adv_o,
  output l3w_state_e state_o,
  output logic       done_o
);
  l3w_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d     = state_q;
    tmr_load_o  = 1'b0;
    tmr_setup_o = 1'b0;
    cap_o       = 1'b0;
    adv_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d     = ST_SETUP;
        tmr_load_o  = 1'b1;
        tmr_setup_o = 1'b1;
        cap_o       = 1'b1;
      end
      ST_SETUP: if (tmr_zero_i) begin
        state_d    = ST_LOW;
        tmr_load_o = 1'b1;
      end
      ST_LOW: if (tmr_zero_i) begin
        state_d    = ST_HIGH;
        tmr_load_o = 1'b1;
      end
      ST_HIGH: if (tmr_zero_i) begin
        if (last_bit_i) state_d = ST_IDLE;
        else begin
          state_d    = ST_LOW;
          tmr_load_o = 1'b1;
          adv_o      = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_HIGH) && (state_d == ST_IDLE);
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_SETUP) || $past(state_q == ST_SETUP));
endmodule

// File: rtl/l3w_master.sv
module l3w_master
  import l3w_pkg::*;
#(
  parameter int unsigned SETUP_CYCLES       = 20,
  parameter int unsigned HALF_PERIOD_CYCLES = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       mode_i,
  output logic       mode_o,
  output logic       bus_clk_o,
  output logic       dat_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int unsigned MAXC = (SETUP_CYCLES > HALF_PERIOD_CYCLES) ? SETUP_CYCLES
                                                                     : HALF_PERIOD_CYCLES;
  localparam int unsigned TW = $clog2(MAXC + 1);
  localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYCLES - 1);
  localparam logic [TW-1:0] HALF_LD  = TW'(HALF_PERIOD_CYCLES - 1);

  l3w_state_e  state;
  logic        tmr_load, tmr_setup, tmr_zero, cap, adv, sh_bit, last_bit;
  logic        mode_q;
  logic [TW-1:0] tmr_val;

  assign tmr_val = tmr_setup ? SETUP_LD : HALF_LD;

  l3w_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .last_bit_i (last_bit),
    .tmr_load_o (tmr_load),
    .tmr_setup_o(tmr_setup),
    .cap_o      (cap),
    .adv_o      (adv),
    .state_o    (state),
    .done_o     (done_o)
  );

  l3w_phase_timer #(.W(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  l3w_shift_reg #(.NBITS(BYTE_BITS)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cap),
    .data_i(byte_i),
    .adv_i (adv),
    .bit_o (sh_bit),
    .last_o(last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mode_q <= 1'b1;
    else if (cap) mode_q <= mode_i;
  end

  assign busy_o    = (state != ST_IDLE);
  assign mode_o    = busy_o ? mode_q : 1'b1;
  assign bus_clk_o = (state != ST_LOW);
  assign dat_o     = ((state == ST_LOW) || (state == ST_HIGH)) ? sh_bit : 1'b0;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R4
  data_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(dat_o)) |-> !bus_clk_o);
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mode_o));
  // R10
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mode_o && bus_clk_o && !dat_o));
endmodule

// File: tb/l3w_master_tb.sv
module l3w_master_tb;
  localparam int SETUP = 3;
  localparam int HALF  = 2;
  localparam int BUSY_LEN = SETUP + 16 * HALF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_in = 1'b0;
  logic [7:0] byte_in = '0;
  logic mode_o, bus_clk_o, dat_o, busy_o, done_o;

  int checks = 0, fails = 0, xfers = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  l3w_master #(.SETUP_CYCLES(SETUP), .HALF_PERIOD_CYCLES(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_i(byte_in), .mode_i(mode_in),
    .mode_o(mode_o), .bus_clk_o(bus_clk_o), .dat_o(dat_o), .busy_o(busy_o), .done_o(done_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: pushes {mode,byte} when a start is accepted
  task automatic send(input logic [7:0] b, input logic m, input bit scramble);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    byte_in = b; mode_in = m; start = 1'b1;
    exp_q.push_back({m, b});
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin  // R9: inputs change after capture
      byte_in = ~b; mode_in = ~m;
    end
  endtask

  // monitor
  logic prev_busy = 1'b0, prev_clk = 1'b1, mode_first = 1'b0, check_done_low = 1'b0;
  logic [7:0] got;
  int busy_cnt, setup_cnt, nbits, run, phase_err, mode_err, setup_err;
  bit seen_low;

  always @(negedge clk) begin
    if (rst_n) begin
      if (check_done_low) begin
        chk(!done_o, "R7", done_o, 0);
        check_done_low <= 1'b0;
      end
      if (busy_o) begin
        if (!prev_busy) begin
          busy_cnt = 0; setup_cnt = 0; nbits = 0; run = 0; phase_err = 0;
          mode_err = 0; setup_err = 0; seen_low = 0; got = '0; mode_first = mode_o;
        end
        busy_cnt++;
        if (mode_o !== mode_first) mode_err++;
        if (!seen_low && bus_clk_o) begin
          setup_cnt++;
          if (dat_o !== 1'b0) setup_err++;
        end
        if (!bus_clk_o) begin
          if (!seen_low) begin seen_low = 1; run = 1; end
          else if (prev_clk) begin
            if (run != HALF) phase_err++;
            run = 1;
          end else run++;
        end else if (seen_low) begin
          if (!prev_clk) begin
            if (run != HALF) phase_err++;
            run = 1;
            if (nbits < 8) got[nbits] = dat_o;
            nbits++;
          end else run++;
        end
      end else if (prev_busy) begin
        logic [8:0] e;
        xfers++;
        if (run != HALF) phase_err++;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1ff;
        chk(got == e[7:0], "R4 byte", got, e[7:0]);
        chk(nbits == 8, "R4 bits", nbits, 8);
        chk(mode_first == e[8] && mode_err == 0, "R2 mode", mode_first, e[8]);
        chk(setup_cnt == SETUP && setup_err == 0, "R3 setup", setup_cnt, SETUP);
        chk(phase_err == 0, "R5 phase", phase_err, 0);
        chk(busy_cnt == BUSY_LEN, "R6 busy", busy_cnt, BUSY_LEN);
        chk(done_o, "R7 done", done_o, 1);
        chk(mode_o && bus_clk_o && !dat_o, "R10 idle", {mode_o, bus_clk_o, dat_o}, 3'b110);
        check_done_low <= 1'b1;
      end
      prev_busy = busy_o;
      prev_clk  = bus_clk_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy_o && !done_o && mode_o && bus_clk_o && !dat_o, "R1 reset",
        {busy_o, done_o, mode_o, bus_clk_o, dat_o}, 5'b00110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && mode_o && bus_clk_o && !dat_o, "R1 release",
        {busy_o, done_o, mode_o, bus_clk_o, dat_o}, 5'b00110);
    send(8'hA5, 1'b0, 0);
    send(8'h3C, 1'b1, 0);
    send(8'h01, 1'b0, 0);
    send(8'h80, 1'b1, 0);
    send(8'h00, 1'b1, 0);
    send(8'hFF, 1'b0, 0);
    send(8'h5A, 1'b1, 1);  // R9
    send(8'hC3, 1'b0, 1);  // R9
    // R8: start mid-transfer is dropped
    send(8'h96, 1'b0, 0);
    repeat (10) @(negedge clk);
    byte_in = 8'h11; mode_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (2 * BUSY_LEN) @(negedge clk);
    chk(!busy_o, "R8 no extra", busy_o, 0);
    chk(xfers == 9, "R8 count", xfers, 9);
    chk(exp_q.size() == 0, "R8 queue", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule